// File: doc/BRIEF.md
# Two-Wire Register Slave Front End

This block is the serial slave side of a small register device that sits on a two-wire bus. SCL and SDA are resynchronised to a fast system clock. The block detects start and stop conditions, checks the slave address byte and runs the transfer types the device supports: a register write, a set-address with no data, a random read (a write of the register address, then a repeated start in read mode) and a current-address read. It drives SDA only as an open-drain pull-down enable. It answers ACK or NACK on the ninth clock of every byte.

On the register side it presents an address pointer, the write data, a one-cycle write strobe, a one-cycle read strobe and a read data input, which is sampled in the same cycle as the read strobe. A busy input marks the time while the nonvolatile store is writing. During that time the block behaves as if absent from the bus.

States and transitions: `S_IDLE` waits for a start, which moves it to `S_DEV`. `S_DEV` gathers the slave address byte. On a match it moves to `S_DEV_ACK`, otherwise back to `S_IDLE`. `S_DEV_ACK` moves to `S_RDATA` for a read or to `S_REG` for a write. `S_REG` gathers the register address and moves to `S_REG_ACK`, which moves to `S_WDATA`. `S_WDATA` gathers a data byte and moves to `S_WDATA_ACK`, which returns to `S_WDATA`. `S_RDATA` shifts a byte out and moves to `S_RD_ACK`. `S_RD_ACK` returns to `S_RDATA` on a master ACK and to `S_IDLE` on a NACK. A stop in any state leads to `S_IDLE`. A start that is not blocked by busy leads to `S_DEV` from any state.

Top module: `twi_reg_slave`

## Requirements
- R1: After reset sda_oe is 0, reg_wr and reg_rd are 0, and reg_addr is 0.
- R2: Bus activity that is not preceded by a start condition (SDA falling while SCL is high) is never acknowledged.
- R3: A slave address byte is accepted only when its bits 7:4 are 0101 and its bits 3:2 are 00; bit 1 may be 0 or 1, and bit 0 selects read (1) or write (0). An accepted byte is acknowledged by pulling SDA low on the ninth clock. A rejected byte gets no acknowledge, and everything up to the next start is ignored.
- R4: A write is the address byte, a register address byte and a data byte, each acknowledged. After the stop (SDA rising while SCL is high), reg_wr pulses for one cycle with reg_addr and reg_wdata holding the register address and the data.
- R5: reg_wr never pulses before the stop. A repeated start after the data byte drops the pending write.
- R6: When the register address is 0x07, a second data byte gets no acknowledge and the first byte is still written. For any other address, extra data bytes are acknowledged and discarded, and only the first byte is written.
- R7: A stop that arrives before the first data byte and its ACK are complete produces no write.
- R8: A stop right after the register address byte loads that address into reg_addr and causes no write. A later read with no address phase returns the register at that address.
- R9: A random read (register address write, repeated start, read-mode address byte) returns the content of the addressed register.
- R10: Read data is shifted out MSB first. It is taken from reg_rdata with a reg_rd pulse on the falling SCL edge that ends each preceding acknowledge. A master ACK makes the slave send the same register again, because the pointer does not advance. A master NACK releases SDA and returns the slave to idle.
- R11: While nv_busy is 1, a start is not recognised, nothing is acknowledged and sda_oe stays 0.
- R12: sda_oe changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the pad |
| sda_i | input | 1 | Serial data line as seen on the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| reg_addr | output | 8 | Register address pointer |
| reg_wdata | output | 8 | Data of the pending write |
| reg_wr | output | 1 | One-cycle write strobe, issued after a stop |
| reg_rd | output | 1 | One-cycle strobe marking the cycle reg_rdata is sampled |
| reg_rdata | input | 8 | Content of the register at reg_addr |
| nv_busy | input | 1 | Nonvolatile write cycle in progress |

## Verification
The hardest situations to reach from the ports are the ones where a bus condition lands in the middle of a byte: a stop after only part of the data byte, and a repeated start after a complete data byte. In both cases the slave state must be discarded without a trace. The bench drives the two lines bit by bit with its own tasks, so it can stop after any number of bits. It then checks that nothing was written by reading the register back through the bus. A per-clock model of the register file, with a queue of expected writes, catches any write strobe that comes early or has no cause.

// File: rtl/twi_reg_pkg.sv
package twi_reg_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [3:0] {
        S_IDLE,
        S_DEV,
        S_DEV_ACK,
        S_REG,
        S_REG_ACK,
        S_WDATA,
        S_WDATA_ACK,
        S_RDATA,
        S_RD_ACK
    } twi_state_e;
endpackage

// File: rtl/twi_sync_chain.sv
module twi_sync_chain #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] ff;

    // Lines idle high, so the chain resets to 1.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff <= '1;
        else        ff <= {ff[STAGES-2:0], d};
    end

    assign q = ff[STAGES-1];
endmodule

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw, syn, prev;

    assign raw = {scl_i, sda_i};

    for (genvar i = 0; i < LINES; i++) begin : g_line
        twi_sync_chain #(.STAGES(STAGES)) u_chain (
            .clk  (clk),
            .rst_n(rst_n),
            .d    (raw[i]),
            .q    (syn[i])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= '1;
        else        prev <= syn;
    end

    assign scl_s    = syn[1];
    assign sda_s    = syn[0];
    assign scl_rise = syn[1] & ~prev[1];
    assign scl_fall = ~syn[1] & prev[1];
    assign start_ev = syn[1] & prev[1] & prev[0] & ~syn[0];
    assign stop_ev  = syn[1] & prev[1] & ~prev[0] & syn[0];
endmodule

// File: rtl/twi_reg_slave.sv
module twi_reg_slave
    import twi_reg_pkg::*;
#(
    parameter int          SYNC_STAGES = 2,
    parameter logic [3:0]  DEV_ID      = 4'b0101,
    parameter logic [1:0]  SEL_HI      = 2'b00,
    parameter logic [7:0]  STATUS_ADDR = 8'h07
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [BYTE_W-1:0] reg_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              reg_wr,
    output logic              reg_rd,
    input  logic [BYTE_W-1:0] reg_rdata,
    input  logic              nv_busy
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;

    twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .scl_s   (scl_s),
        .sda_s   (sda_s),
        .scl_rise(scl_rise),
        .scl_fall(scl_fall),
        .start_ev(start_ev),
        .stop_ev (stop_ev)
    );

    twi_state_e        state;
    logic [BYTE_W-1:0] shreg, ptr, wdata_q;
    logic [CNT_W-1:0]  cnt;
    logic              rw_q, ack_q, have_data, mack_q;
    logic              dev_match;

    assign dev_match = (shreg[7:4] == DEV_ID) && (shreg[3:2] == SEL_HI);

    // State register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            shreg     <= '0;
            cnt       <= '0;
            ptr       <= '0;
            wdata_q   <= '0;
            rw_q      <= 1'b0;
            ack_q     <= 1'b0;
            have_data <= 1'b0;
            mack_q    <= 1'b0;
            reg_wr    <= 1'b0;
            reg_rd    <= 1'b0;
        end else begin
            reg_wr <= 1'b0;
            reg_rd <= 1'b0;
            if (stop_ev) begin
                reg_wr    <= have_data;
                have_data <= 1'b0;
                ack_q     <= 1'b0;
                state     <= S_IDLE;
            end else if (start_ev && !nv_busy) begin
                have_data <= 1'b0;
                ack_q     <= 1'b0;
                cnt       <= '0;
                state     <= S_DEV;
            end else begin
                unique case (state)
                    S_IDLE: ;
                    S_DEV, S_REG, S_WDATA: begin
                        if (scl_rise && cnt != FULL) begin
                            shreg <= {shreg[BYTE_W-2:0], sda_s};
                            cnt   <= cnt + 1'b1;
                        end else if (scl_fall && cnt == FULL) begin
                            cnt <= '0;
                            if (state == S_DEV) begin
                                if (dev_match && !nv_busy) begin
                                    state <= S_DEV_ACK;
                                    ack_q <= 1'b1;
                                    rw_q  <= shreg[0];
                                end else begin
                                    state <= S_IDLE;
                                end
                            end else if (state == S_REG) begin
                                state <= S_REG_ACK;
                                ack_q <= 1'b1;
                                ptr   <= shreg;
                            end else begin
                                state <= S_WDATA_ACK;
                                ack_q <= !(have_data && ptr == STATUS_ADDR);
                                if (!have_data) wdata_q <= shreg;
                            end
                        end
                    end
                    S_DEV_ACK: begin
                        if (scl_fall) begin
                            ack_q <= 1'b0;
                            cnt   <= '0;
                            if (rw_q) begin
                                state  <= S_RDATA;
                                shreg  <= reg_rdata;
                                reg_rd <= 1'b1;
                            end else begin
                                state <= S_REG;
                            end
                        end
                    end
                    S_REG_ACK: begin
                        if (scl_fall) begin
                            ack_q <= 1'b0;
                            state <= S_WDATA;
                        end
                    end
                    S_WDATA_ACK: begin
                        if (scl_fall) begin
                            ack_q     <= 1'b0;
                            have_data <= 1'b1;
                            state     <= S_WDATA;
                        end
                    end
                    S_RDATA: begin
                        if (scl_fall) begin
                            if (cnt == LAST) begin
                                cnt   <= '0;
                                state <= S_RD_ACK;
                            end else begin
                                shreg <= {shreg[BYTE_W-2:0], 1'b0};
                                cnt   <= cnt + 1'b1;
                            end
                        end
                    end
                    S_RD_ACK: begin
                        if (scl_rise) begin
                            mack_q <= !sda_s;
                        end else if (scl_fall) begin
                            if (mack_q) begin
                                state  <= S_RDATA;
                                shreg  <= reg_rdata;
                                reg_rd <= 1'b1;
                            end else begin
                                state <= S_IDLE;
                            end
                        end
                    end
                endcase
            end
        end
    end

    // Output decode
    always_comb begin
        unique case (state)
            S_DEV_ACK, S_REG_ACK, S_WDATA_ACK: sda_oe = ack_q;
            S_RDATA:                           sda_oe = !shreg[BYTE_W-1];
            default:                           sda_oe = 1'b0;
        endcase
    end

    assign reg_addr  = ptr;
    assign reg_wdata = wdata_q;

    // R4 / R5: a write strobe always follows a detected stop
    a_r5_write_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> $past(stop_ev));

    // R7: a stop with no complete data byte leaves no write behind
    a_r7_early_stop_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_ev && !have_data) |=> !reg_wr);

    // R11: while busy the slave stays idle
    a_r11_busy_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && nv_busy) |=> (state == S_IDLE));

    // R12: the pull-down only moves while SCL is low
    a_r12_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_s);

    // R6: second data byte to the status register is not acknowledged
    a_r6_status_second_nack: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WDATA_ACK && have_data && ptr == STATUS_ADDR) |-> !sda_oe);
endmodule

// File: tb/twi_reg_slave_tb.sv
module twi_reg_slave_tb;
    localparam int Q = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       nv_busy = 1'b0;
    logic       sda_oe, reg_wr, reg_rd;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    logic       sda_line;
    logic [7:0] regs [8];
    logic [15:0] exp_wr [$];
    int         vectors = 0;
    int         miscompares = 0;
    int         rd_pulses = 0;
    logic       quiet = 1'b0;
    logic       prev_oe = 1'b0;
    logic       done = 1'b0;

    always #2.5 clk = ~clk;

    assign sda_line  = sda_m & ~sda_oe;
    assign reg_rdata = regs[reg_addr[2:0]];

    twi_reg_slave u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_m),
        .sda_i    (sda_line),
        .sda_oe   (sda_oe),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_wr   (reg_wr),
        .reg_rd   (reg_rd),
        .reg_rdata(reg_rdata),
        .nv_busy  (nv_busy)
    );

    // Per-clock reference: register file, expected writes, pin rules
    always @(negedge clk) begin
        if (rst_n) begin
            vectors++;
            if (sda_oe !== prev_oe && scl_m) begin
                miscompares++;
                $display("FAIL R12 sda_oe changed with SCL high: actual=%0b expected=%0b", sda_oe, prev_oe);
            end
            if (quiet && sda_oe) begin
                miscompares++;
                $display("FAIL R11 sda_oe while busy: actual=1 expected=0");
            end
            if (reg_wr) begin
                if (exp_wr.size() == 0) begin
                    miscompares++;
                    $display("FAIL R5 unexpected write: actual=%0h expected=none", {reg_addr, reg_wdata});
                end else begin
                    logic [15:0] e;
                    e = exp_wr.pop_front();
                    if ({reg_addr, reg_wdata} !== e) begin
                        miscompares++;
                        $display("FAIL R4 write content: actual=%0h expected=%0h", {reg_addr, reg_wdata}, e);
                    end
                end
                regs[reg_addr[2:0]] = reg_wdata;
            end
            if (reg_rd) rd_pulses++;
            prev_oe = sda_oe;
        end
    end

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic qwait();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; qwait();
        scl_m = 1'b1; qwait();
        sda_m = 1'b0; qwait();
        scl_m = 1'b0; qwait();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; qwait();
        scl_m = 1'b1; qwait();
        sda_m = 1'b1; qwait();
        qwait();
    endtask

    task automatic clk_bit(input logic b, output logic seen);
        sda_m = b;    qwait();
        scl_m = 1'b1; qwait();
        seen = sda_line;
        qwait();
        scl_m = 1'b0; qwait();
    endtask

    task automatic send_byte(input logic [7:0] v, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(v[i], s);
        clk_bit(1'b1, s);
        acked = !s;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] v);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            v[i] = s;
        end
        clk_bit(!give_ack, s);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(negedge clk);
        miscompares++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin : stim
        logic       a;
        logic [7:0] d;
        int         rd0;
        for (int i = 0; i < 8; i++) regs[i] = 8'h3C + 8'(i * 17);

        repeat (5) @(negedge clk);
        check("R1 sda_oe", {31'd0, sda_oe}, 32'd0);
        check("R1 strobes", {30'd0, reg_wr, reg_rd}, 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 reg_addr", {24'd0, reg_addr}, 32'd0);

        // R2: a valid address byte without any start
        scl_m = 1'b0; qwait();
        send_byte(8'h50, a);
        check("R2 no ack without start", {31'd0, a}, 32'd0);

        // R3: identifier and select matching
        bus_start(); send_byte(8'h50, a); check("R3 select 000 ack", {31'd0, a}, 32'd1); bus_stop();
        bus_start(); send_byte(8'h52, a); check("R3 select 001 ack", {31'd0, a}, 32'd1); bus_stop();
        bus_start(); send_byte(8'h54, a); check("R3 select 010 nack", {31'd0, a}, 32'd0);
        send_byte(8'h00, a); check("R3 ignored after nack", {31'd0, a}, 32'd0); bus_stop();
        bus_start(); send_byte(8'h60, a); check("R3 wrong id nack", {31'd0, a}, 32'd0); bus_stop();

        // R4: plain write, strobe only at stop (R5)
        bus_start(); send_byte(8'h50, a); check("R4 dev ack", {31'd0, a}, 32'd1);
        send_byte(8'h00, a); check("R4 reg ack", {31'd0, a}, 32'd1);
        send_byte(8'hA5, a); check("R4 data ack", {31'd0, a}, 32'd1);
        exp_wr.push_back({8'h00, 8'hA5});
        bus_stop();
        check("R4 write issued", exp_wr.size(), 32'd0);

        // R9: random read of register 0
        bus_start(); send_byte(8'h50, a); send_byte(8'h00, a);
        bus_start(); send_byte(8'h51, a); check("R9 read dev ack", {31'd0, a}, 32'd1);
        recv_byte(1'b0, d); bus_stop();
        check("R9 random read data", {24'd0, d}, 32'hA5);

        // R8: set address, then current-address read
        bus_start(); send_byte(8'h50, a); send_byte(8'h03, a); bus_stop();
        check("R8 pointer loaded", {24'd0, reg_addr}, 32'h03);
        bus_start(); send_byte(8'h51, a); recv_byte(1'b0, d); bus_stop();
        check("R8 current read", {24'd0, d}, 32'h3C + 32'd51);

        // R10: sequential read repeats the same register
        rd0 = rd_pulses;
        bus_start(); send_byte(8'h53, a);
        recv_byte(1'b1, d); check("R10 first byte", {24'd0, d}, 32'h6F);
        recv_byte(1'b0, d); check("R10 repeat byte", {24'd0, d}, 32'h6F);
        bus_stop();
        check("R10 read strobes", rd_pulses - rd0, 32'd2);
        check("R10 released after nack", {31'd0, sda_oe}, 32'd0);

        // R6: status register accepts a single data byte
        bus_start(); send_byte(8'h50, a); send_byte(8'h07, a);
        send_byte(8'h08, a); check("R6 status first ack", {31'd0, a}, 32'd1);
        send_byte(8'h55, a); check("R6 status second nack", {31'd0, a}, 32'd0);
        exp_wr.push_back({8'h07, 8'h08});
        bus_stop();
        check("R6 status write", exp_wr.size(), 32'd0);
        bus_start(); send_byte(8'h50, a); send_byte(8'h02, a);
        send_byte(8'h11, a); send_byte(8'h22, a); check("R6 other second ack", {31'd0, a}, 32'd1);
        exp_wr.push_back({8'h02, 8'h11});
        bus_stop();
        bus_start(); send_byte(8'h51, a); recv_byte(1'b0, d); bus_stop();
        check("R6 first byte kept", {24'd0, d}, 32'h11);

        // R7: stop in the middle of the data byte
        bus_start(); send_byte(8'h50, a); send_byte(8'h01, a);
        for (int i = 0; i < 4; i++) clk_bit(1'b0, a);
        bus_stop();
        bus_start(); send_byte(8'h51, a); recv_byte(1'b0, d); bus_stop();
        check("R7 register untouched", {24'd0, d}, 32'h4D);
        bus_start(); send_byte(8'h50, a); bus_stop();
        check("R7 no write queued", exp_wr.size(), 32'd0);

        // R5: repeated start after the data byte drops the write
        bus_start(); send_byte(8'h50, a); send_byte(8'h04, a); send_byte(8'h99, a);
        bus_start(); send_byte(8'h51, a); recv_byte(1'b0, d); bus_stop();
        check("R5 dropped write", {24'd0, d}, 32'h80);

        // R11: busy makes the slave silent
        nv_busy = 1'b1; quiet = 1'b1;
        bus_start(); send_byte(8'h50, a); check("R11 busy no ack", {31'd0, a}, 32'd0);
        send_byte(8'h00, a); check("R11 busy data no ack", {31'd0, a}, 32'd0);
        bus_stop();
        nv_busy = 1'b0; quiet = 1'b0;
        bus_start(); send_byte(8'h50, a); check("R11 ack after busy", {31'd0, a}, 32'd1); bus_stop();

        check("R4 no pending writes", exp_wr.size(), 32'd0);
        finish_run();
    end
endmodule